// File: doc/BRIEF.md
# USB Suspend and Remote Wake-Up Controller

This block decides when a USB device function goes to sleep and how it wakes up. It watches the decoded bus line state. When the bus has been idle (J) for a set number of millisecond ticks without a break, the block enters suspend and drops its clock-run request. While suspended, it watches a group of general-purpose input pins. A falling edge on any pin that the wake mask leaves open is a wake event. The event sets a sticky wake flag, ends suspend at once and asks for the clocks to run again. If the interrupt enable is set, the flag also raises an interrupt that carries the same vector code as the external interrupt pin. Firmware clears the flag with a one-cycle strobe.

During suspend, the external interrupt pin takes the place of one port bit, so that pin can also wake the function. Bus activity from the host ends suspend without setting the wake flag. For resume signaling, firmware holds a resume request high. The block drives the K state for as long as the request is high, and keeps driving it for an extra interval of one to two milliseconds after the request falls.

All port and interrupt-pin inputs pass through a two-stage synchronizer before edge detection. Time is measured in a single-cycle millisecond tick. Every signal is a plain level or strobe, so the block has no streaming interface and no back-pressure.

Top module: `usb_suspend_wake`

## Requirements
- R1: After reset, `suspended`=0, `clk_run`=1, `drive_k`=0, `irq`=0 and `irq_vec`=0x00.
- R2: Suspend starts once `line_idle` has been 1 across IDLE_MS (default 5) consecutive `ms_tick` pulses. Any cycle with `line_idle`=0 restarts the count, so fewer than IDLE_MS ticks after the break do not suspend. While suspended, `clk_run` is 0.
- R3: While suspended, a 1-to-0 transition on a port bit whose `wake_mask` bit is 0 sets the wake flag. In the same cycle, `suspended` goes to 0 and `clk_run` goes to 1.
- R4: A falling edge on a bit whose mask bit is 1, a rising edge on any bit, and any edge while not suspended all leave the wake flag clear and `irq` at 0.
- R5: `irq` is 1 exactly while the wake flag is set and `irq_en` is 1. `irq_vec` is 0x1F while `irq` is 1 and 0x00 otherwise. With `irq_en`=0, a wake still ends suspend.
- R6: While suspended, port bit XINT_BIT (default 2) is taken from `xint_pin`, and `port_in[2]` is ignored. A falling `xint_pin` wakes the block only if `wake_mask[2]` is 0.
- R7: The wake flag stays set until a `wake_clr` strobe. While it is set, the idle count stays at zero and suspend cannot be entered. After the clear, a fresh IDLE_MS ticks are needed before suspend.
- R8: `drive_k` is 1 while `fw_resume` is 1 and stays 1 after it falls until the EXT_TICKS-th (default 2) `ms_tick` that follows. It is 0 from the cycle after that tick.
- R9: While suspended, `line_idle`=0 ends suspend and leaves the wake flag clear (`irq` stays 0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low reset |
| ms_tick | input | 1 | One-cycle pulse each millisecond |
| line_idle | input | 1 | Decoded bus state is idle (J) |
| port_in | input | PORT_W | General-purpose port pins (asynchronous) |
| xint_pin | input | 1 | External interrupt pin (asynchronous) |
| wake_mask | input | PORT_W | 1 blocks wake on that bit |
| irq_en | input | 1 | Allow the wake flag to raise the interrupt |
| wake_clr | input | 1 | One-cycle strobe that clears the wake flag |
| fw_resume | input | 1 | Firmware resume request (level) |
| suspended | output | 1 | Block is in suspend |
| clk_run | output | 1 | Request that all clocks run |
| drive_k | output | 1 | Request to drive the K state on the bus |
| irq | output | 1 | Interrupt request |
| irq_vec | output | 8 | Interrupt vector code |

## Verification
The hardest case to reach is the remapping of the interrupt pin onto port bit 2 during suspend. The test has to tell apart three outcomes: a port-bit-2 edge that is ignored, an interrupt-pin edge that is masked, and an interrupt-pin edge that wakes. All three must happen inside one suspend period, and the block must stay suspended after each of the first two. The bench first enters suspend through a tick sequence that is deliberately broken by one non-idle cycle. It then toggles the three inputs in turn and checks the state after each one. The sequence ends with the unmasked interrupt-pin edge, first with the interrupt disabled and then with it enabled.

// File: rtl/usbsw_pkg.sv
package usbsw_pkg;
  localparam logic [7:0] WAKE_VEC = 8'h1F;
  typedef enum logic { PS_ACTIVE = 1'b0, PS_SUSP = 1'b1 } pwr_st_t;
endpackage

// File: rtl/usbsw_sync.sv
module usbsw_sync #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_async,
  output logic [W-1:0] q_sync
);
  for (genvar b = 0; b < W; b++) begin : g_bit
    logic s1, s2;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        s1 <= 1'b1;
        s2 <= 1'b1;
      end else begin
        s1 <= d_async[b];
        s2 <= s1;
      end
    end
    assign q_sync[b] = s2;
  end
endmodule

// File: rtl/usbsw_idle_timer.sv
module usbsw_idle_timer #(
  parameter int IDLE_MS = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ms_tick,
  input  logic line_idle,
  input  logic hold,
  output logic expired
);
  localparam int CW = $clog2(IDLE_MS + 1);
  localparam logic [CW-1:0] LIMIT = CW'(IDLE_MS);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     cnt <= '0;
    else if (!line_idle || hold)    cnt <= '0;
    else if (ms_tick && cnt != LIMIT) cnt <= cnt + 1'b1;
  end

  assign expired = (cnt == LIMIT);
endmodule

// File: rtl/usbsw_wake_ctl.sv
module usbsw_wake_ctl
  import usbsw_pkg::*;
#(
  parameter int PORT_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              idle_expired,
  input  logic              line_idle,
  input  logic              k_busy,
  input  logic [PORT_W-1:0] pins,
  input  logic [PORT_W-1:0] wake_mask,
  input  logic              wake_clr,
  output logic              suspended,
  output logic              wake_flag
);
  pwr_st_t st, st_nx;
  logic [PORT_W-1:0] pins_q;
  logic              susp_d1;
  logic [PORT_W-1:0] fall_open;
  logic              wake_term;

  assign fall_open = pins_q & ~pins & ~wake_mask;
  assign wake_term = (st == PS_SUSP) && susp_d1 && (|fall_open);

  always_comb begin
    st_nx = st;
    unique case (st)
      PS_ACTIVE: if (idle_expired && !wake_flag && !k_busy) st_nx = PS_SUSP;
      PS_SUSP:   if (wake_term || !line_idle)               st_nx = PS_ACTIVE;
      default:   st_nx = PS_ACTIVE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= PS_ACTIVE;
      susp_d1   <= 1'b0;
      pins_q    <= '1;
      wake_flag <= 1'b0;
    end else begin
      st      <= st_nx;
      susp_d1 <= (st == PS_SUSP);
      pins_q  <= pins;
      if (wake_term)     wake_flag <= 1'b1;
      else if (wake_clr) wake_flag <= 1'b0;
    end
  end

  assign suspended = (st == PS_SUSP);
endmodule

// File: rtl/usbsw_resume_ext.sv
module usbsw_resume_ext #(
  parameter int EXT_TICKS = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ms_tick,
  input  logic fw_resume,
  output logic drive_k
);
  localparam int CW = $clog2(EXT_TICKS + 1);
  localparam logic [CW-1:0] LOAD = CW'(EXT_TICKS);

  logic          fw_q;
  logic [CW-1:0] ext_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fw_q    <= 1'b0;
      ext_cnt <= '0;
    end else begin
      fw_q <= fw_resume;
      if (fw_q && !fw_resume)            ext_cnt <= LOAD;
      else if (fw_resume)                ext_cnt <= '0;
      else if (ms_tick && ext_cnt != '0) ext_cnt <= ext_cnt - 1'b1;
    end
  end

  assign drive_k = fw_resume | fw_q | (ext_cnt != '0);
endmodule

// File: rtl/usb_suspend_wake.sv
module usb_suspend_wake
  import usbsw_pkg::*;
#(
  parameter int PORT_W    = 8,
  parameter int XINT_BIT  = 2,
  parameter int IDLE_MS   = 5,
  parameter int EXT_TICKS = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ms_tick,
  input  logic              line_idle,
  input  logic [PORT_W-1:0] port_in,
  input  logic              xint_pin,
  input  logic [PORT_W-1:0] wake_mask,
  input  logic              irq_en,
  input  logic              wake_clr,
  input  logic              fw_resume,
  output logic              suspended,
  output logic              clk_run,
  output logic              drive_k,
  output logic              irq,
  output logic [7:0]        irq_vec
);
  localparam int SW = PORT_W + 1;

  logic [SW-1:0]     sync_q;
  logic [PORT_W-1:0] pins_eff;
  logic              idle_expired;
  logic              wake_flag;

  usbsw_sync #(.W(SW)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .d_async({xint_pin, port_in}),
    .q_sync(sync_q)
  );

  for (genvar b = 0; b < PORT_W; b++) begin : g_mux
    if (b == XINT_BIT) begin : g_x
      assign pins_eff[b] = suspended ? sync_q[PORT_W] : sync_q[b];
    end else begin : g_p
      assign pins_eff[b] = sync_q[b];
    end
  end

  usbsw_idle_timer #(.IDLE_MS(IDLE_MS)) u_idle (
    .clk(clk), .rst_n(rst_n),
    .ms_tick(ms_tick),
    .line_idle(line_idle),
    .hold(suspended | wake_flag | drive_k),
    .expired(idle_expired)
  );

  usbsw_wake_ctl #(.PORT_W(PORT_W)) u_wake (
    .clk(clk), .rst_n(rst_n),
    .idle_expired(idle_expired),
    .line_idle(line_idle),
    .k_busy(drive_k),
    .pins(pins_eff),
    .wake_mask(wake_mask),
    .wake_clr(wake_clr),
    .suspended(suspended),
    .wake_flag(wake_flag)
  );

  usbsw_resume_ext #(.EXT_TICKS(EXT_TICKS)) u_ext (
    .clk(clk), .rst_n(rst_n),
    .ms_tick(ms_tick),
    .fw_resume(fw_resume),
    .drive_k(drive_k)
  );

  assign clk_run = ~suspended;
  assign irq     = wake_flag & irq_en;
  assign irq_vec = irq ? WAKE_VEC : 8'h00;
endmodule

// File: rtl/usbsw_chk.sv
module usbsw_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       line_idle,
  input logic       fw_resume,
  input logic       irq_en,
  input logic       suspended,
  input logic       clk_run,
  input logic       drive_k,
  input logic       irq,
  input logic [7:0] irq_vec,
  input logic       wake_flag
);
  // R2
  susp_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(suspended) |-> $past(line_idle));

  // R7
  no_resuspend_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(suspended) |-> !$past(wake_flag));

  // R3
  wake_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wake_flag) |-> (!suspended && clk_run));

  // R8
  k_stretch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(fw_resume) |-> drive_k);

  // R5
  irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (irq_en && wake_flag && irq_vec == 8'h1F));
endmodule

bind usb_suspend_wake usbsw_chk u_chk (
  .clk(clk), .rst_n(rst_n), .line_idle(line_idle), .fw_resume(fw_resume),
  .irq_en(irq_en), .suspended(suspended), .clk_run(clk_run),
  .drive_k(drive_k), .irq(irq), .irq_vec(irq_vec), .wake_flag(wake_flag)
);

// File: tb/usb_suspend_wake_tb.sv
module usb_suspend_wake_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ms_tick = 1'b0;
  logic       line_idle = 1'b1;
  logic [7:0] port_in = 8'hFF;
  logic       xint_pin = 1'b1;
  logic [7:0] wake_mask = 8'h00;
  logic       irq_en = 1'b0;
  logic       wake_clr = 1'b0;
  logic       fw_resume = 1'b0;
  logic       suspended, clk_run, drive_k, irq;
  logic [7:0] irq_vec;

  always #5 clk = ~clk;

  usb_suspend_wake u_dut (
    .clk(clk), .rst_n(rst_n), .ms_tick(ms_tick), .line_idle(line_idle),
    .port_in(port_in), .xint_pin(xint_pin), .wake_mask(wake_mask),
    .irq_en(irq_en), .wake_clr(wake_clr), .fw_resume(fw_resume),
    .suspended(suspended), .clk_run(clk_run), .drive_k(drive_k),
    .irq(irq), .irq_vec(irq_vec)
  );

  typedef struct {
    string      tag;
    logic       s, c, k, i;
    logic [7:0] v;
  } exp_t;

  exp_t exp_q[$];
  int   n_chk = 0;
  int   n_bad = 0;
  bit   done  = 1'b0;

  task automatic expect_out(string tag, logic s, logic c, logic k, logic i, logic [7:0] v);
    exp_t e;
    e.tag = tag; e.s = s; e.c = c; e.k = k; e.i = i; e.v = v;
    exp_q.push_back(e);
    #1;
  endtask

  initial begin
    forever begin
      exp_t e;
      wait (exp_q.size() != 0);
      e = exp_q.pop_front();
      n_chk++;
      if (suspended !== e.s || clk_run !== e.c || drive_k !== e.k ||
          irq !== e.i || irq_vec !== e.v) begin
        n_bad++;
        $display("FAIL %s: actual susp=%b run=%b k=%b irq=%b vec=%h expected susp=%b run=%b k=%b irq=%b vec=%h",
                 e.tag, suspended, clk_run, drive_k, irq, irq_vec, e.s, e.c, e.k, e.i, e.v);
      end
    end
  end

  task automatic cyc(int n);
    for (int j = 0; j < n; j++) @(negedge clk);
  endtask

  task automatic tick();
    @(negedge clk) ms_tick = 1'b1;
    @(negedge clk) ms_tick = 1'b0;
    cyc(2);
  endtask

  task automatic ticks(int n);
    for (int j = 0; j < n; j++) tick();
  endtask

  task automatic clr_pulse();
    @(negedge clk) wake_clr = 1'b1;
    @(negedge clk) wake_clr = 1'b0;
    cyc(1);
  endtask

  initial begin
    cyc(3);
    rst_n = 1'b1;
    cyc(2);
    expect_out("R1 reset", 0, 1, 0, 0, 8'h00);

    // R2: broken idle run, then full run
    ticks(3);
    @(negedge clk) line_idle = 1'b0;
    @(negedge clk) line_idle = 1'b1;
    ticks(4);
    expect_out("R2 restart after break", 0, 1, 0, 0, 8'h00);
    ticks(1);
    expect_out("R2 suspend after idle run", 1, 0, 0, 0, 8'h00);

    // R4: masked bit ignored, rising ignored
    wake_mask = 8'h01;
    port_in[0] = 1'b0; cyc(6);
    expect_out("R4 masked fall", 1, 0, 0, 0, 8'h00);
    port_in[0] = 1'b1; cyc(6);
    expect_out("R4 rising edge", 1, 0, 0, 0, 8'h00);

    // R6: bit 2 comes from interrupt pin
    port_in[2] = 1'b0; cyc(6);
    expect_out("R6 port bit2 ignored", 1, 0, 0, 0, 8'h00);
    port_in[2] = 1'b1; cyc(6);
    wake_mask = 8'h04;
    xint_pin = 1'b0; cyc(6);
    expect_out("R6 masked xint", 1, 0, 0, 0, 8'h00);
    xint_pin = 1'b1; cyc(6);
    wake_mask = 8'h00;
    xint_pin = 1'b0; cyc(6);
    expect_out("R6 R5 xint wake irq off", 0, 1, 0, 0, 8'h00);
    irq_en = 1'b1; cyc(1);
    expect_out("R5 irq enabled vec", 0, 1, 0, 1, 8'h1F);
    xint_pin = 1'b1; cyc(4);

    // R7: flag blocks suspend until cleared
    ticks(7);
    expect_out("R7 no suspend with flag", 0, 1, 0, 1, 8'h1F);
    clr_pulse();
    expect_out("R7 flag cleared", 0, 1, 0, 0, 8'h00);
    ticks(4);
    expect_out("R7 fresh count needed", 0, 1, 0, 0, 8'h00);
    ticks(1);
    expect_out("R7 suspend after clear", 1, 0, 0, 0, 8'h00);

    // R3: port wake with irq
    port_in[5] = 1'b0; cyc(6);
    expect_out("R3 port wake", 0, 1, 0, 1, 8'h1F);
    port_in[5] = 1'b1; cyc(4);
    clr_pulse();

    // R4: edge while active
    port_in[5] = 1'b0; cyc(6);
    expect_out("R4 edge while active", 0, 1, 0, 0, 8'h00);
    port_in[5] = 1'b1; cyc(4);

    // R9: bus activity ends suspend
    ticks(5);
    expect_out("R9 suspended", 1, 0, 0, 0, 8'h00);
    @(negedge clk) line_idle = 1'b0;
    cyc(2);
    expect_out("R9 host resume", 0, 1, 0, 0, 8'h00);

    // R8: resume stretch
    fw_resume = 1'b1; cyc(10);
    expect_out("R8 k during pulse", 0, 1, 1, 0, 8'h00);
    fw_resume = 1'b0; cyc(5);
    expect_out("R8 k after fall", 0, 1, 1, 0, 8'h00);
    tick();
    expect_out("R8 k after first tick", 0, 1, 1, 0, 8'h00);
    @(negedge clk) ms_tick = 1'b1;
    @(negedge clk) ms_tick = 1'b0;
    expect_out("R8 k off after last tick", 0, 1, 0, 0, 8'h00);

    cyc(2);
    done = 1'b1;
  end

  initial begin
    for (int j = 0; j < 100000; j++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual running expected done");
    end
    #1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule